// File: doc/BRIEF.md
# Strobed Watchdog Timer with Write-Protect

This block is a watchdog that counts down one step on each pulse of a slow time base, nominally 32 Hz. The pulse arrives as a single-cycle enable. Software controls the block through one 8-bit control word. That word holds three fields: a strobe that restarts the countdown, a protect bit that freezes the interval, and a 6-bit interval multiplier. The time-out is the multiplier times one base period. At 32 Hz this gives 31.25 ms at a multiplier of 1 and about 2 s at 0x3F. A multiplier of 0 turns the watchdog off.

When the countdown runs out, the block sets a sticky watchdog flag and gives a one-cycle interrupt request to a separate interrupt block. The flag stays set until that interrupt block pulses the flag-clear input. After an expiry the countdown stays stopped until software restarts it.

With protect set, software can strobe repeatedly without any risk of changing the interval. The protect value that decides whether the multiplier is written is the one stored by an earlier write. The protect value carried in the current write does not count.

Top module: `wdt_strobed`

## Requirements
- R1: After synchronous reset, the multiplier is 0, protect is 0, the flag is 0, the interrupt request is 0 and the control word reads 0x00.
- R2: The control word reads as {bit7 = 0, bit6 = protect, bits5..0 = multiplier}. The strobe (bit 7) always reads 0.
- R3: Every write loads protect from bit 6. Bits 5..0 are loaded into the multiplier only if the stored protect was 0 before that write.
- R4: A write with bit 7 = 1 reloads the countdown from the multiplier in effect after the write. The expiry happens on the N-th tick after the reload, where N is the multiplier, and not earlier.
- R5: A write whose multiplier bits are accepted also restarts the countdown from the new value, even with bit 7 = 0.
- R6: With a multiplier of 0, any number of ticks gives no expiry.
- R7: On expiry, the flag goes high and the interrupt request is high for exactly one cycle. Both are visible in the cycle after the clock edge that sampled the final tick.
- R8: The flag stays high until flag_clr is sampled high. If an expiry and a clear occur in the same cycle, the flag is set.
- R9: After an expiry the countdown is stopped. Further ticks give no new interrupt until a reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Control word write data |
| rd_data | output | 8 | Control word read value |
| tick | input | 1 | One-cycle time base enable |
| flag_clr | input | 1 | Clears the watchdog flag |
| wdog_flag | output | 1 | Sticky watchdog expiry flag |
| wdog_irq | output | 1 | One-cycle interrupt request on expiry |

## Verification
A write is captured at the next clock edge, so its read value is checked one cycle after it is driven. Each expiry is due exactly one cycle after the edge that samples the N-th tick. The driver pushes that cycle number into a queue when it drives the final tick. A monitor sampling at the falling edge pops the queue on every interrupt and compares cycles, so an interrupt that comes early or late, or was never expected, is flagged. The bench also checks the flag one tick short of expiry and across later ticks, which covers the stopped countdown and the sticky flag.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    parameter int MULT_W = 6;
    localparam int WORD_W = MULT_W + 2;

    typedef struct packed {
        logic              strobe;
        logic              prot;
        logic [MULT_W-1:0] mult;
    } wdt_word_t;

    function automatic wdt_word_t to_word(input logic [WORD_W-1:0] raw);
        return wdt_word_t'(raw);
    endfunction

    function automatic logic [WORD_W-1:0] read_view(input logic prot,
                                                    input logic [MULT_W-1:0] mult);
        return {1'b0, prot, mult};
    endfunction
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              prot,
    output logic [MULT_W-1:0] mult,
    output logic              reload,
    output logic [MULT_W-1:0] load_val
);
    wdt_word_t   wr_w;
    logic        mult_open;

    assign wr_w      = to_word(wr_data);
    assign mult_open = wr_en && !prot;
    assign reload    = wr_en && (wr_w.strobe || !prot);
    assign load_val  = mult_open ? wr_w.mult : mult;

    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= 1'b0;
            mult <= '0;
        end else if (wr_en) begin
            prot <= wr_w.prot;
            if (mult_open) mult <= wr_w.mult;
        end
    end

    // R3
    mult_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && prot) |=> $stable(mult));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reload,
    input  logic [MULT_W-1:0] load_val,
    input  logic              tick,
    output logic              hit
);
    logic [MULT_W-1:0] cnt;
    logic              running;

    assign hit = tick && running && !reload && (cnt == MULT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (reload) begin
            cnt     <= load_val;
            running <= (load_val != '0);
        end else if (tick && running) begin
            cnt <= cnt - MULT_W'(1);
            if (cnt == MULT_W'(1)) running <= 1'b0;
        end
    end

    // R9
    stop_after_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && !reload) |=> !running);

    // R6
    run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt != '0));
endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq  <= hit;
            flag <= hit || (flag && !clr);
        end
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);
endmodule

// File: rtl/wdt_strobed.sv
module wdt_strobed
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              tick,
    input  logic              flag_clr,
    output logic              wdog_flag,
    output logic              wdog_irq
);
    logic              prot;
    logic [MULT_W-1:0] mult;
    logic              reload;
    logic [MULT_W-1:0] load_val;
    logic              hit;

    wdt_cfg_reg u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .prot(prot), .mult(mult), .reload(reload), .load_val(load_val)
    );

    wdt_countdown u_cnt (
        .clk(clk), .rst(rst), .reload(reload), .load_val(load_val),
        .tick(tick), .hit(hit)
    );

    wdt_flag u_flag (
        .clk(clk), .rst(rst), .hit(hit), .clr(flag_clr),
        .flag(wdog_flag), .irq(wdog_irq)
    );

    assign rd_data = read_view(prot, mult);

    // R2
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_data[WORD_W-1]);

    // R7
    irq_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_irq |-> wdog_flag);

    // R6
    irq_needs_mult_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_irq |-> (rd_data[MULT_W-1:0] != '0));
endmodule

// File: tb/sim_wdt_strobed.sv
module sim_wdt_strobed;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick = 1'b0;
    logic       flag_clr = 1'b0;
    logic [7:0] rd_data;
    logic       wdog_flag;
    logic       wdog_irq;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int exp_c;
    bit done = 0;
    int exp_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdt_strobed u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .flag_clr(flag_clr),
        .wdog_flag(wdog_flag), .wdog_irq(wdog_irq)
    );

    task automatic step(input bit w, input logic [7:0] d, input bit t, input bit c);
        @(posedge clk); #1;
        wr_en = w; wr_data = d; tick = t; flag_clr = c;
    endtask

    task automatic idle();
        step(0, 8'h00, 0, 0);
    endtask

    task automatic wr(input logic [7:0] d);
        step(1, d, 0, 0);
        idle();
    endtask

    task automatic ticks(input int n, input bit expect_last);
        for (int i = 0; i < n; i++) begin
            step(0, 8'h00, 1, 0);
            if (expect_last && i == n - 1) exp_q.push_back(cyc + 1);
            idle();
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    // Monitor: every interrupt must match the next expected cycle (R7, R4)
    always @(negedge clk) begin
        if (!rst && wdog_irq) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R9 unexpected irq at cycle actual=%0d expected=none", cyc);
            end else begin
                exp_c = exp_q.pop_front();
                if (exp_c != cyc) begin
                    failures++;
                    $display("FAIL R4 irq cycle actual=%0d expected=%0d", cyc, exp_c);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        at_neg();
        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 flag", wdog_flag, 0);
        check("R1 irq", wdog_irq, 0);

        // R5: accepted multiplier write starts countdown of 5
        wr(8'h05);
        at_neg();
        check("R2 read 0x05", rd_data, 8'h05);
        ticks(4, 0);
        at_neg();
        check("R4 no flag one tick short", wdog_flag, 0);
        ticks(1, 1);
        at_neg();
        check("R7 flag set", wdog_flag, 1);
        // R9 stopped after expiry, R8 sticky
        ticks(6, 0);
        at_neg();
        check("R8 flag sticky", wdog_flag, 1);
        step(0, 8'h00, 0, 1); idle();
        at_neg();
        check("R8 flag cleared", wdog_flag, 0);

        // R3: set protect while still open -> multiplier 3 accepted
        wr(8'h43);
        at_neg();
        check("R3 prot+mult", rd_data, 8'h43);
        ticks(2, 0);
        // R4: strobe with protect kept, multiplier bits ignored
        wr(8'hFF);
        at_neg();
        check("R3 mult locked", rd_data, 8'h43);
        ticks(2, 0);
        at_neg();
        check("R4 strobe restarted count", wdog_flag, 0);
        ticks(1, 1);
        at_neg();
        check("R4 flag after reload", wdog_flag, 1);
        step(0, 8'h00, 0, 1); idle();

        // R3: clearing protect does not write mult in same cycle
        wr(8'h8A);
        at_neg();
        check("R2 strobe reads 0, R3 mult kept", rd_data, 8'h03);
        // R6: now write 0 -> disabled
        wr(8'h00);
        at_neg();
        check("R6 disabled read", rd_data, 8'h00);
        wr(8'h80);
        ticks(70, 0);
        at_neg();
        check("R6 no expiry when disabled", wdog_flag, 0);

        // R8: expiry and clear in the same cycle -> flag set
        wr(8'h01);
        step(0, 8'h00, 1, 1);
        exp_q.push_back(cyc + 1);
        idle();
        at_neg();
        check("R8 set wins over clear", wdog_flag, 1);
        step(0, 8'h00, 0, 1); idle();
        at_neg();
        check("R8 cleared again", wdog_flag, 0);

        // R4: maximum multiplier
        wr(8'h3F);
        ticks(62, 0);
        at_neg();
        check("R4 max no early expiry", wdog_flag, 0);
        ticks(1, 1);
        at_neg();
        check("R7 max flag", wdog_flag, 1);

        repeat (3) idle();
        check("R7 all expected irqs seen", exp_q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule